// File: doc/BRIEF.md
# Two-Channel Shared-Clock PWM Slice

This block is a register-programmed pulse-width modulator holding two channels that share one clock configuration. The shared stage picks one of two incoming clock-enable strobes, an oscillator-rate strobe or a bus-rate strobe, and thins it by a power-of-two divider. Each channel then divides the shared tick again by its own prescaler. It counts the result in a 16-bit period counter and compares the count against an active-phase length to shape its output. Each channel has its own polarity, enable and gating bits. Its pad is driven through an output value and an output-enable, so a disabled channel leaves its pin floating.

Software programs the slice through a simple write port and a combinational read port. New divider, prescale and period values act on the running waveform at once and do not wait for the period in progress to end. Each channel is a small state machine with three states. `ST_OFF` means disabled, with the pad released. `ST_ON` is the active phase and `ST_REST` is the inactive phase. The machine goes from any state to `ST_OFF` when the enable bit is clear. From any state with the enable bit set, it goes to `ST_ON` when the next count is below the clamped active length, and to `ST_REST` otherwise.

Top module: `pwm_duo_slice`

## Requirements
- R1: After a synchronous reset every register reads zero, both output-enables are low and both outputs are low.
- R2: The register map decodes as follows, and unmapped addresses read zero.
  - 0x020 is the shared clock word: source in bits [8:7], divider exponent m in bits [3:0].
  - 0x040 is the gate word: gating bit ch at bit ch, bypass bit ch at bit ch+16.
  - 0x080 is the enable word: bit ch per channel.
  - 0x100 + 0x20*ch is the channel control word: prescale k in [7:0], polarity in bit 8.
  - 0x104 + 0x20*ch is the channel period word: entire count E in [31:16], active count A in [15:0].
  - Unimplemented bits read back as zero.
- R3: A source field of 0 counts the oscillator strobe. Any nonzero source field counts the bus strobe.
- R4: The shared tick fires once every 2^m selected strobes. An exponent above 8 behaves exactly as 8.
- R5: Each channel counts one tick per k+1 shared ticks, using its own k. Both channels keep the shared divider.
- R6: A channel period lasts E+1 channel ticks. The first A ticks of the period, while the count is below A, form the active phase.
- R7: An active count larger than the entire count is treated as equal to the entire count.
- R8: With polarity bit 1 the output is high in the active phase and low otherwise. With polarity bit 0 the levels are swapped.
- R9: A channel whose enable bit is clear drives its output-enable low and its output low. A channel whose enable bit is set drives its output-enable high.
- R10: A channel's counter advances only while both its gating bit and its enable bit are set. Otherwise the output stays frozen.
- R11: A write to the period word takes effect within a few cycles, even in the middle of a long period.
- R12: The bypass bits are stored and read back, and they do not change the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | Oscillator-rate clock-enable strobe |
| bus_tick | input | 1 | Bus-rate clock-enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Register read data, combinational |
| pwm_out | output | 2 | Per-channel output value |
| pwm_oe | output | 2 | Per-channel output-enable (low means high impedance) |

## Verification
The bench builds the slice with its defaults: two channels, 16-bit counters, an 8-bit prescaler and a divider exponent capped at 8. With the cap at 8, a period of 512 cycles is enough to show that an exponent of 12 behaves like 8. The 16-bit counter lets a 1000-tick period be rewritten halfway through, which exposes any design that waits for the period to end. The bus strobe arrives every third cycle and the oscillator strobe every cycle, so the source selection shows up as a different edge rate at the same duty.

// File: rtl/pwm_duo_pkg.sv
package pwm_duo_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_REST = 2'd2
    } ch_state_e;

    localparam int unsigned OFS_CLKCFG = 32'h020;
    localparam int unsigned OFS_GATE   = 32'h040;
    localparam int unsigned OFS_ENA    = 32'h080;
    localparam int unsigned OFS_CTL0   = 32'h100;
    localparam int unsigned OFS_PER0   = 32'h104;
    localparam int unsigned OFS_STRIDE = 32'h020;

    localparam int unsigned SRC_LSB    = 7;
    localparam int unsigned BYP_LSB    = 16;

endpackage

// File: rtl/pwm_duo_regs.sv
module pwm_duo_regs
    import pwm_duo_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 8,
    parameter int DIV_W  = 4,
    parameter int ADDR_W = 12,
    localparam int DATA_W = 2 * CNT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic [1:0]                  cfg_src,
    output logic [DIV_W-1:0]            cfg_div,
    output logic [N_CH-1:0]             gate_on,
    output logic [N_CH-1:0]             ch_ena,
    output logic [N_CH-1:0][PSC_W-1:0]  ch_k,
    output logic [N_CH-1:0]             ch_pol,
    output logic [N_CH-1:0][CNT_W-1:0]  ch_ent,
    output logic [N_CH-1:0][CNT_W-1:0]  ch_act
);

    logic [N_CH-1:0] byp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_src <= '0;
            cfg_div <= '0;
            gate_on <= '0;
            byp_q   <= '0;
            ch_ena  <= '0;
            ch_k    <= '0;
            ch_pol  <= '0;
            ch_ent  <= '0;
            ch_act  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(OFS_CLKCFG)) begin
                cfg_src <= wr_data[SRC_LSB +: 2];
                cfg_div <= wr_data[DIV_W-1:0];
            end
            if (wr_addr == ADDR_W'(OFS_GATE)) begin
                gate_on <= wr_data[N_CH-1:0];
                byp_q   <= wr_data[BYP_LSB +: N_CH];
            end
            if (wr_addr == ADDR_W'(OFS_ENA)) begin
                ch_ena <= wr_data[N_CH-1:0];
            end
            for (int c = 0; c < N_CH; c++) begin
                if (wr_addr == ADDR_W'(OFS_CTL0 + c * OFS_STRIDE)) begin
                    ch_k[c]   <= wr_data[PSC_W-1:0];
                    ch_pol[c] <= wr_data[PSC_W];
                end
                if (wr_addr == ADDR_W'(OFS_PER0 + c * OFS_STRIDE)) begin
                    ch_ent[c] <= wr_data[DATA_W-1:CNT_W];
                    ch_act[c] <= wr_data[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_CLKCFG)) begin
            rd_data[SRC_LSB +: 2] = cfg_src;
            rd_data[DIV_W-1:0]    = cfg_div;
        end
        if (rd_addr == ADDR_W'(OFS_GATE)) begin
            rd_data[N_CH-1:0]        = gate_on;
            rd_data[BYP_LSB +: N_CH] = byp_q;
        end
        if (rd_addr == ADDR_W'(OFS_ENA)) begin
            rd_data[N_CH-1:0] = ch_ena;
        end
        for (int c = 0; c < N_CH; c++) begin
            if (rd_addr == ADDR_W'(OFS_CTL0 + c * OFS_STRIDE)) begin
                rd_data[PSC_W-1:0] = ch_k[c];
                rd_data[PSC_W]     = ch_pol[c];
            end
            if (rd_addr == ADDR_W'(OFS_PER0 + c * OFS_STRIDE)) begin
                rd_data = {ch_ent[c], ch_act[c]};
            end
        end
    end

endmodule

// File: rtl/pwm_duo_pairclk.sv
module pwm_duo_pairclk #(
    parameter int DIV_W   = 4,
    parameter int DIV_MAX = 8,
    localparam int PH_W   = DIV_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             bus_tick,
    input  logic [1:0]       cfg_src,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             pair_tick
);

    logic             src_tick;
    logic [DIV_W-1:0] m_eff;
    logic [PH_W-1:0]  mask;
    logic [PH_W-1:0]  phase_q;

    always_comb begin
        src_tick  = (cfg_src != 2'b00) ? bus_tick : osc_tick;
        m_eff     = (cfg_div > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : cfg_div;
        mask      = ~({PH_W{1'b1}} << m_eff);
        pair_tick = src_tick && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (src_tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_duo_chan.sv
module pwm_duo_chan
    import pwm_duo_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_tick,
    input  logic             gate_on,
    input  logic             enable,
    input  logic [PSC_W-1:0] k,
    input  logic             pol,
    input  logic [CNT_W-1:0] ent,
    input  logic [CNT_W-1:0] act,
    output logic             out,
    output logic             oe,
    output logic             run_o,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o
);

    ch_state_e        state_q, state_nx;
    logic [PSC_W-1:0] psc_q, psc_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] act_eff;
    logic             run, tick, phase_on;

    always_comb begin
        run     = gate_on && enable;
        tick    = run && pair_tick && (psc_q >= k);
        psc_nx  = psc_q;
        if (run && pair_tick) begin
            psc_nx = (psc_q >= k) ? '0 : psc_q + 1'b1;
        end
        cnt_nx  = cnt_q;
        if (tick) begin
            cnt_nx = (cnt_q >= ent) ? '0 : cnt_q + 1'b1;
        end
        act_eff  = (act > ent) ? ent : act;
        phase_on = cnt_nx < act_eff;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:  if (enable) state_nx = phase_on ? ST_ON : ST_REST;
            ST_ON:   if (!enable) state_nx = ST_OFF;
                     else if (!phase_on) state_nx = ST_REST;
            ST_REST: if (!enable) state_nx = ST_OFF;
                     else if (phase_on) state_nx = ST_ON;
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            psc_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            psc_q   <= psc_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_comb begin
        out = 1'b0;
        oe  = 1'b0;
        unique case (state_q)
            ST_OFF:  begin out = 1'b0; oe = 1'b0; end
            ST_ON:   begin out = pol;  oe = 1'b1; end
            ST_REST: begin out = ~pol; oe = 1'b1; end
            default: begin out = 1'b0; oe = 1'b0; end
        endcase
    end

    assign run_o  = run;
    assign tick_o = tick;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/pwm_duo_slice.sv
module pwm_duo_slice #(
    parameter int N_CH    = 2,
    parameter int CNT_W   = 16,
    parameter int PSC_W   = 8,
    parameter int DIV_W   = 4,
    parameter int DIV_MAX = 8,
    parameter int ADDR_W  = 12,
    localparam int DATA_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              bus_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_CH-1:0]   pwm_out,
    output logic [N_CH-1:0]   pwm_oe
);

    logic [1:0]                 cfg_src;
    logic [DIV_W-1:0]           cfg_div;
    logic [N_CH-1:0]            gate_on, ch_ena, ch_pol;
    logic [N_CH-1:0][PSC_W-1:0] ch_k;
    logic [N_CH-1:0][CNT_W-1:0] ch_ent, ch_act, ch_cnt;
    logic [N_CH-1:0]            ch_run, ch_tick;
    logic                       pair_tick;

    pwm_duo_regs #(
        .N_CH(N_CH), .CNT_W(CNT_W), .PSC_W(PSC_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_src(cfg_src), .cfg_div(cfg_div),
        .gate_on(gate_on), .ch_ena(ch_ena), .ch_k(ch_k), .ch_pol(ch_pol),
        .ch_ent(ch_ent), .ch_act(ch_act)
    );

    pwm_duo_pairclk #(
        .DIV_W(DIV_W), .DIV_MAX(DIV_MAX)
    ) i_pairclk (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_tick(bus_tick),
        .cfg_src(cfg_src), .cfg_div(cfg_div), .pair_tick(pair_tick)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pwm_duo_chan #(
            .CNT_W(CNT_W), .PSC_W(PSC_W)
        ) i_chan (
            .clk(clk), .rst(rst), .pair_tick(pair_tick), .gate_on(gate_on[c]),
            .enable(ch_ena[c]), .k(ch_k[c]), .pol(ch_pol[c]), .ent(ch_ent[c]),
            .act(ch_act[c]), .out(pwm_out[c]), .oe(pwm_oe[c]), .run_o(ch_run[c]),
            .tick_o(ch_tick[c]), .cnt_o(ch_cnt[c])
        );
    end

endmodule

// File: rtl/pwm_duo_slice_chk.sv
module pwm_duo_slice_chk
    import pwm_duo_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 12,
    localparam int DATA_W = 2 * CNT_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       osc_tick,
    input logic                       bus_tick,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic [DATA_W-1:0]          rd_data,
    input logic [N_CH-1:0]            pwm_out,
    input logic [N_CH-1:0]            pwm_oe,
    input logic [1:0]                 cfg_src,
    input logic                       pair_tick,
    input logic [N_CH-1:0]            ch_run,
    input logic [N_CH-1:0]            ch_tick,
    input logic [N_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [N_CH-1:0][CNT_W-1:0] ch_ent
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwm_oe == '0 && rd_data == '0));

    // R3
    tick_source_chk: assert property (@(posedge clk) disable iff (rst)
        pair_tick |-> ((cfg_src == 2'b00) ? osc_tick : bus_tick));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        // R9
        disable_float_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(OFS_ENA) && !wr_data[c]) |=> ##1 !pwm_oe[c]);

        // R9
        float_low_chk: assert property (@(posedge clk) disable iff (rst)
            !pwm_oe[c] |-> !pwm_out[c]);

        // R10
        hold_count_chk: assert property (@(posedge clk) disable iff (rst)
            !ch_run[c] |=> $stable(ch_cnt[c]));

        // R6
        period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (ch_tick[c] && ch_cnt[c] >= ch_ent[c]) |=> ch_cnt[c] == '0);
    end

endmodule

bind pwm_duo_slice pwm_duo_slice_chk #(
    .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_tick(bus_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .cfg_src(cfg_src), .pair_tick(pair_tick),
    .ch_run(ch_run), .ch_tick(ch_tick), .ch_cnt(ch_cnt), .ch_ent(ch_ent)
);

// File: tb/test_pwm_duo_slice.sv
module test_pwm_duo_slice;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b1;
    logic        bus_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  pwm_out, pwm_oe;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pwm_duo_slice i_pwm_duo_slice (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_tick(bus_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    initial begin
        int bc;
        bc = 0;
        forever begin
            @(negedge clk);
            bc = (bc + 1) % 3;
            bus_tick = (bc == 0);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic measure(input int ch, input int settle, input int win,
                           output int hi, output int rises);
        logic prev;
        repeat (settle) @(negedge clk);
        prev = pwm_out[ch];
        hi = 0; rises = 0;
        repeat (win) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
            if (pwm_out[ch] && !prev) rises++;
            prev = pwm_out[ch];
        end
    endtask

    task automatic run_ch0(input logic [31:0] cfg, input logic [31:0] ctl, input logic [31:0] per);
        wr(12'h020, cfg);
        wr(12'h100, ctl);
        wr(12'h104, per);
        wr(12'h040, 32'h1);
        wr(12'h080, 32'h1);
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk("R1 clkcfg", 12'h020, 0);
        rd_chk("R1 gate", 12'h040, 0);
        rd_chk("R1 enable", 12'h080, 0);
        rd_chk("R1 period1", 12'h124, 0);
        chk("R1 oe", pwm_oe, 0);
        chk("R1 out", pwm_out, 0);
    endtask

    task automatic t_readback();
        do_reset();
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h080, 32'hFFFF_FFFF);
        wr(12'h120, 32'hFFFF_FFFF);
        wr(12'h104, 32'hDEAD_BEEF);
        wr(12'h124, 32'h1234_5678);
        wr(12'h060, 32'hFFFF_FFFF);
        rd_chk("R2 clkcfg mask", 12'h020, 32'h0000_018F);
        rd_chk("R2 gate mask", 12'h040, 32'h0003_0003);
        rd_chk("R12 bypass readback", 12'h040, 32'h0003_0003);
        rd_chk("R2 enable mask", 12'h080, 32'h0000_0003);
        rd_chk("R2 ctl1 mask", 12'h120, 32'h0000_01FF);
        rd_chk("R2 ctl0 untouched", 12'h100, 0);
        rd_chk("R2 period0", 12'h104, 32'hDEAD_BEEF);
        rd_chk("R2 period1", 12'h124, 32'h1234_5678);
        rd_chk("R2 unmapped", 12'h060, 0);
    endtask

    task automatic t_basic();
        int hi, ri;
        do_reset();
        run_ch0(32'h0, 32'h100, (32'd4 << 16) | 32'd2);
        measure(0, 20, 100, hi, ri);
        chk("R6 N5 A2 high", hi, 40);
        chk("R6 N5 A2 rises", ri, 20);
        wr(12'h104, (32'd7 << 16) | 32'd5);
        measure(0, 20, 80, hi, ri);
        chk("R6 N8 A5 high", hi, 50);
        chk("R6 N8 A5 rises", ri, 10);
        chk("R9 oe enabled ch0", pwm_oe[0], 1);
        chk("R9 oe disabled ch1", pwm_oe[1], 0);
    endtask

    task automatic t_pol();
        int hi, ri;
        do_reset();
        run_ch0(32'h0, 32'h000, (32'd4 << 16) | 32'd2);
        measure(0, 20, 100, hi, ri);
        chk("R8 inverted high", hi, 60);
    endtask

    task automatic t_src();
        int hi, ri;
        do_reset();
        run_ch0(32'h080, 32'h100, (32'd3 << 16) | 32'd2);
        measure(0, 30, 120, hi, ri);
        chk("R3 bus src=1 high", hi, 60);
        chk("R3 bus src=1 rises", ri, 10);
        wr(12'h020, 32'h100);
        measure(0, 30, 120, hi, ri);
        chk("R3 bus src=2 rises", ri, 10);
        wr(12'h020, 32'h000);
        measure(0, 30, 120, hi, ri);
        chk("R3 osc src=0 high", hi, 60);
        chk("R3 osc src=0 rises", ri, 30);
    endtask

    task automatic t_div();
        int hi, ri;
        do_reset();
        run_ch0(32'h002, 32'h101, (32'd3 << 16) | 32'd1);
        measure(0, 70, 320, hi, ri);
        chk("R4 m2 k1 high", hi, 80);
        chk("R5 m2 k1 rises", ri, 10);
        do_reset();
        run_ch0(32'h00C, 32'h100, (32'd1 << 16) | 32'd1);
        measure(0, 1100, 1024, hi, ri);
        chk("R4 m12 as 8 high", hi, 512);
        chk("R4 m12 as 8 rises", ri, 2);
    endtask

    task automatic t_pair();
        int hi, ri;
        do_reset();
        wr(12'h020, 32'h001);
        wr(12'h100, 32'h100);
        wr(12'h104, (32'd3 << 16) | 32'd1);
        wr(12'h120, 32'h102);
        wr(12'h124, (32'd1 << 16) | 32'd1);
        wr(12'h040, 32'h3);
        wr(12'h080, 32'h3);
        measure(0, 30, 240, hi, ri);
        chk("R5 ch0 k0 high", hi, 60);
        chk("R5 ch0 k0 rises", ri, 30);
        measure(1, 0, 240, hi, ri);
        chk("R5 ch1 k2 high", hi, 120);
        chk("R5 ch1 k2 rises", ri, 20);
    endtask

    task automatic t_clamp();
        int hi, ri;
        do_reset();
        run_ch0(32'h0, 32'h100, (32'd3 << 16) | 32'd10);
        measure(0, 20, 40, hi, ri);
        chk("R7 act>ent high", hi, 30);
        wr(12'h104, (32'd0 << 16) | 32'd5);
        measure(0, 10, 40, hi, ri);
        chk("R7 ent0 clamp high", hi, 0);
    endtask

    task automatic t_disable();
        do_reset();
        run_ch0(32'h0, 32'h000, (32'd4 << 16) | 32'd2);
        repeat (10) @(negedge clk);
        chk("R9 oe on", pwm_oe[0], 1);
        wr(12'h080, 32'h0);
        repeat (2) @(negedge clk);
        chk("R9 oe off", pwm_oe[0], 0);
        chk("R9 out low off", pwm_out[0], 0);
    endtask

    task automatic t_gate();
        int hi, ri;
        do_reset();
        wr(12'h020, 32'h0);
        wr(12'h100, 32'h100);
        wr(12'h104, (32'd4 << 16) | 32'd2);
        wr(12'h080, 32'h1);
        measure(0, 5, 50, hi, ri);
        chk("R10 gated frozen high", hi, 50);
        chk("R10 gated no edges", ri, 0);
        chk("R9 oe while gated", pwm_oe[0], 1);
        wr(12'h040, 32'h1);
        measure(0, 10, 100, hi, ri);
        chk("R10 ungated high", hi, 40);
        chk("R10 ungated rises", ri, 20);
    endtask

    task automatic t_bypass();
        int hi, ri;
        do_reset();
        wr(12'h020, 32'h0);
        wr(12'h100, 32'h100);
        wr(12'h104, (32'd4 << 16) | 32'd2);
        wr(12'h040, 32'h0001_0001);
        wr(12'h080, 32'h1);
        measure(0, 20, 100, hi, ri);
        chk("R12 bypass high", hi, 40);
        chk("R12 bypass rises", ri, 20);
    endtask

    task automatic t_mid();
        int hi, ri;
        logic seen;
        do_reset();
        run_ch0(32'h0, 32'h100, (32'd999 << 16) | 32'd500);
        repeat (600) @(negedge clk);
        chk("R11 inactive before rewrite", pwm_out[0], 0);
        wr(12'h104, (32'd3 << 16) | 32'd2);
        seen = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (pwm_out[0]) seen = 1'b1;
        end
        chk("R11 new period at once", seen, 1);
        measure(0, 8, 40, hi, ri);
        chk("R11 new duty high", hi, 20);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_readback();
        t_basic();
        t_pol();
        t_src();
        t_div();
        t_pair();
        t_clamp();
        t_disable();
        t_gate();
        t_bypass();
        t_mid();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule